// File: doc/BRIEF.md
# Stoppable Local Clock Generator

This block derives a slow local module clock from a free-running fast reference clock. A phase counter measures out each half of the local period in reference cycles, which stands in for the delay of an inverter ring. An internal run flag lets the local clock rise when its low half is complete. While the flag is clear, the clock waits in its low phase. A high phase, once started, always runs to its full length.

The block also owns the handshake that pauses the local module while it waits for an asynchronous partner. When the local side signals that it needs data, the request goes out on a local rising edge, and the run flag clears on that same edge. The partner's acknowledge passes through a synchronizer. It then releases the clock and completes a four-phase exchange. If the acknowledge arrives late, the low phase is lengthened by the wait. If it arrives early, the period is unchanged. A status output reports how many reference cycles the most recent low phase was held beyond its nominal length.

Top module: `stopclk_gen`

## Requirements
- R1: While reset is held, localClk is 0, partnerReq is 0 and holdCycles is 0.
- R2: With no request outstanding, localClk stays high for exactly HALF_CNT reference cycles and then low for exactly HALF_CNT reference cycles, repeating.
- R3: A request is issued only on the reference edge where localClk rises, and only when needData is high at that edge. partnerReq and localClk go high together.
- R4: A high phase of localClk is never shortened. This includes the high phase in which a request was issued, which still lasts HALF_CNT reference cycles.
- R5: partnerAck passes through SYNC_STAGES synchronizer flops. When ack is first captured at reference edge A and the low phase began at edge F, localClk rises at edge max(F+HALF_CNT, A+SYNC_STAGES). Any stall lengthens only the low phase.
- R6: If the acknowledge is captured early enough that A+SYNC_STAGES is not later than F+HALF_CNT, the low phase keeps its nominal HALF_CNT length.
- R7: partnerReq stays high until the synchronized acknowledge is seen. It falls at edge A+SYNC_STAGES.
- R8: While partnerAck is still high after a completed exchange, no new request is issued and localClk keeps running at its nominal rate. Once the acknowledge has fallen and passed through the synchronizer, a pending need is served at the next rising edge.
- R9: At each rising edge of localClk, holdCycles is loaded with the number of reference cycles the just-finished low phase lasted beyond HALF_CNT. It holds that value until the next rising edge.
- R10: If needData is low at a rising edge, no request is issued and the clock is not paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running fast reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| needData | input | 1 | Local module wants data from the partner at the next local rising edge |
| partnerAck | input | 1 | Acknowledge from the asynchronous partner |
| partnerReq | output | 1 | Four-phase request to the partner |
| localClk | output | 1 | Generated stoppable local clock |
| holdCycles | output | HOLD_W | Reference cycles the most recent low phase was held beyond nominal |

## Verification
The main instance uses HALF_CNT of 3 with a two-flop synchronizer. With this setting, the acknowledge delay sweep covers both regimes: an acknowledge that lands inside the nominal low phase, and one that forces a stall of several cycles. For each delay the bench computes the expected low length and the expected hold count. Three further instances with HALF_CNT of 1, 2 and 5 run free so that the period arithmetic is checked at the degenerate single-cycle half and at a longer one. A separate exchange keeps the acknowledge high after release, to show that requests are suppressed while the clock keeps its nominal rate.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

  // Control to datapath: permission for the clock to leave its low phase.
  typedef struct packed {
    logic goRun;
  } ctlStb_t;

  // Datapath to control: the reference edge at which the local clock rises.
  typedef struct packed {
    logic riseEv;
  } dpEvt_t;

endpackage

// File: rtl/stopclk_dp.sv
module stopclk_dp
  import stopclk_pkg::*;
#(
  parameter int HALF_CNT = 3,
  parameter int HOLD_W   = 16
) (
  input  logic              refClk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  output dpEvt_t            evt,
  output logic              localClk,
  output logic [HOLD_W-1:0] holdCycles
);

  localparam int CW = (HALF_CNT > 1) ? $clog2(HALF_CNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CNT - 1);

  logic [CW-1:0]     phaseCnt;
  logic              clkQ;
  logic [HOLD_W-1:0] stallCnt;
  logic [HOLD_W-1:0] holdQ;
  logic              highDone;
  logic              lowDone;

  assign highDone   = clkQ && (phaseCnt == LAST);
  assign lowDone    = !clkQ && (phaseCnt == LAST);
  assign evt.riseEv = lowDone && stb.goRun;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      clkQ     <= 1'b0;
      phaseCnt <= '0;
      stallCnt <= '0;
      holdQ    <= '0;
    end else if (highDone) begin
      // high phase always completes; stopping is possible only when low
      clkQ     <= 1'b0;
      phaseCnt <= '0;
    end else if (evt.riseEv) begin
      clkQ     <= 1'b1;
      phaseCnt <= '0;
      holdQ    <= stallCnt;
      stallCnt <= '0;
    end else if (lowDone) begin
      // waiting in the low phase: count the stretch, saturating
      if (stallCnt != '1) stallCnt <= stallCnt + 1'b1;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  assign localClk   = clkQ;
  assign holdCycles = holdQ;

endmodule

// File: rtl/stopclk_ctrl.sv
module stopclk_ctrl
  import stopclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    refClk,
  input  logic    rstN,
  input  logic    needData,
  input  logic    partnerAck,
  input  dpEvt_t  evt,
  output ctlStb_t stb,
  output logic    partnerReq
);

  logic [SYNC_STAGES-1:0] ackSync;
  logic                   ackS;
  logic                   runQ;
  logic                   reqQ;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      ackSync <= '0;
    end else begin
      ackSync[0] <= partnerAck;
      for (int i = 1; i < SYNC_STAGES; i++) ackSync[i] <= ackSync[i-1];
    end
  end

  assign ackS = ackSync[SYNC_STAGES-1];

  // the synchronized acknowledge releases the clock in the same cycle it is seen
  assign stb.goRun = runQ | (reqQ & ackS);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b1;
      reqQ <= 1'b0;
    end else if (evt.riseEv && needData && !reqQ && !ackS) begin
      reqQ <= 1'b1;
      runQ <= 1'b0;
    end else if (reqQ && ackS) begin
      reqQ <= 1'b0;
      runQ <= 1'b1;
    end
  end

  assign partnerReq = reqQ;

endmodule

// File: rtl/stopclk_gen.sv
module stopclk_gen
  import stopclk_pkg::*;
#(
  parameter int HALF_CNT    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_W      = 16
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic              needData,
  input  logic              partnerAck,
  output logic              partnerReq,
  output logic              localClk,
  output logic [HOLD_W-1:0] holdCycles
);

  ctlStb_t stb;
  dpEvt_t  evt;

  stopclk_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .refClk     (refClk),
    .rstN       (rstN),
    .needData   (needData),
    .partnerAck (partnerAck),
    .evt        (evt),
    .stb        (stb),
    .partnerReq (partnerReq)
  );

  stopclk_dp #(.HALF_CNT(HALF_CNT), .HOLD_W(HOLD_W)) u_dp (
    .refClk     (refClk),
    .rstN       (rstN),
    .stb        (stb),
    .evt        (evt),
    .localClk   (localClk),
    .holdCycles (holdCycles)
  );

endmodule

// File: rtl/stopclk_gen_chk.sv
module stopclk_gen_chk #(
  parameter int HALF_CNT = 3,
  parameter int HOLD_W   = 16
) (
  input logic              refClk,
  input logic              rstN,
  input logic              localClk,
  input logic              partnerReq,
  input logic              partnerAck,
  input logic [HOLD_W-1:0] holdCycles
);

  int highRun;
  int lowRun;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      highRun <= 0;
      lowRun  <= 0;
    end else if (localClk) begin
      highRun <= highRun + 1;
      lowRun  <= 0;
    end else begin
      lowRun  <= lowRun + 1;
      highRun <= 0;
    end
  end

  // R4
  high_full_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(localClk) |-> highRun == HALF_CNT);

  // R5
  low_min_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(localClk) |-> lowRun >= HALF_CNT);

  // R3
  req_on_rise_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(partnerReq) |-> $rose(localClk));

  // R7
  req_drop_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(partnerReq) |-> $past(partnerAck));

  // R8
  no_reissue_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(partnerReq) |-> !$past(partnerAck));

  // R9
  hold_stable_chk: assert property (@(posedge refClk) disable iff (!rstN)
    !$rose(localClk) |-> $stable(holdCycles));

endmodule

bind stopclk_gen stopclk_gen_chk #(.HALF_CNT(HALF_CNT), .HOLD_W(HOLD_W)) u_chk (
  .refClk     (refClk),
  .rstN       (rstN),
  .localClk   (localClk),
  .partnerReq (partnerReq),
  .partnerAck (partnerAck),
  .holdCycles (holdCycles)
);

// File: tb/stopclk_gen_tb.sv
module stopclk_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 3;
  localparam int SYNC       = 2;
  localparam int HW         = 16;

  logic          refClk = 1'b0;
  logic          rstN;
  logic          needData;
  logic          partnerAck;
  logic          partnerReq;
  logic          localClk;
  logic [HW-1:0] holdCycles;

  int nChecks = 0;
  int nErrors = 0;

  // tracking, updated only inside step()
  logic prevClk = 1'b0;
  int   highCnt = 0;
  int   lowCnt = 0;
  int   lastHighLen = -1;
  int   lastLowLen = -1;
  int   riseCount = 0;
  logic reqEver = 1'b0;

  always #(CLK_PERIOD/2) refClk = ~refClk;

  stopclk_gen #(.HALF_CNT(H), .SYNC_STAGES(SYNC), .HOLD_W(HW)) u_dut (
    .refClk     (refClk),
    .rstN       (rstN),
    .needData   (needData),
    .partnerAck (partnerAck),
    .partnerReq (partnerReq),
    .localClk   (localClk),
    .holdCycles (holdCycles)
  );

  // free-running sweep over other half-period values (R2)
  for (genvar g = 0; g < 3; g++) begin : g_sweep
    localparam int HV = (g == 0) ? 1 : (g == 1) ? 2 : 5;
    logic          sClk;
    logic          sReq;
    logic [HW-1:0] sHold;
    int nChk = 0;
    int nErr = 0;
    int runLen = 0;
    int edges = 0;
    logic sPrev = 1'b0;

    stopclk_gen #(.HALF_CNT(HV), .SYNC_STAGES(SYNC), .HOLD_W(HW)) u_sweep (
      .refClk     (refClk),
      .rstN       (rstN),
      .needData   (1'b0),
      .partnerAck (1'b0),
      .partnerReq (sReq),
      .localClk   (sClk),
      .holdCycles (sHold)
    );

    always @(negedge refClk) begin
      if (rstN) begin
        if (sClk != sPrev) begin
          edges = edges + 1;
          if (edges > 2 && edges < 40) begin
            nChk = nChk + 1;
            if (runLen != HV || sReq !== 1'b0) begin
              nErr = nErr + 1;
              $display("FAIL R2 sweep half=%0d: actual len %0d req %0b expected len %0d req 0",
                       HV, runLen, sReq, HV);
            end
          end
          runLen = 1;
        end else begin
          runLen = runLen + 1;
        end
        sPrev = sClk;
      end
    end
  end

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge refClk);
    if (localClk) begin
      if (!prevClk) begin
        lastLowLen = lowCnt;
        highCnt    = 0;
        riseCount++;
      end
      highCnt++;
    end else begin
      if (prevClk) begin
        lastHighLen = highCnt;
        lowCnt      = 0;
      end
      lowCnt++;
    end
    prevClk = localClk;
    if (partnerReq) reqEver = 1'b1;
  endtask

  task automatic waitReq(input string tag);
    int n = 0;
    while (!partnerReq && n < 60) begin
      step();
      n++;
    end
    check({tag, " request seen"}, partnerReq, 1);
  endtask

  task automatic finishRun();
    for (int g = 0; g < 3; g++) begin
      case (g)
        0: begin nChecks += g_sweep[0].nChk; nErrors += g_sweep[0].nErr; end
        1: begin nChecks += g_sweep[1].nChk; nErrors += g_sweep[1].nErr; end
        default: begin nChecks += g_sweep[2].nChk; nErrors += g_sweep[2].nErr; end
      endcase
    end
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge refClk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int rc;
    rstN       = 1'b0;
    needData   = 1'b0;
    partnerAck = 1'b0;
    repeat (3) @(negedge refClk);
    // R1 reset state
    check("R1 localClk", localClk, 0);
    check("R1 partnerReq", partnerReq, 0);
    check("R1 holdCycles", holdCycles, 0);
    rstN = 1'b1;

    // R2 / R10: free run without needData
    reqEver = 1'b0;
    repeat (40) step();
    check("R2 high length", lastHighLen, H);
    check("R2 low length", lastLowLen, H);
    check("R10 no request", reqEver, 0);
    check("R10 no hold", holdCycles, 0);

    // acknowledge delay sweep: R3..R7, R9
    for (int d = 0; d <= 9; d++) begin
      needData = 1'b1;
      waitReq("R3");
      check("R3 request on rising edge", highCnt, 1);
      check("R3 clock high with request", localClk, 1);
      needData = 1'b0;
      rc = riseCount;
      for (int j = 0; j < d; j++) begin
        step();
        check("R7 request held before ack", partnerReq, 1);
      end
      partnerAck = 1'b1;
      step();
      check("R7 request held during sync", partnerReq, 1);
      step();
      check("R7 request held during sync", partnerReq, 1);
      step();
      check("R7 request drops after sync", partnerReq, 0);
      for (int n = 0; n < 60 && riseCount == rc; n++) step();
      check("R4 requesting high phase full", lastHighLen, H);
      if (d + SYNC + 1 - H <= H)
        check("R6 early ack low length", lastLowLen, imax(H, d + SYNC + 1 - H));
      else
        check("R5 stretched low length", lastLowLen, imax(H, d + SYNC + 1 - H));
      check("R9 hold count", holdCycles, imax(0, d + SYNC + 1 - 2*H));
      partnerAck = 1'b0;
      repeat (4*H) step();
    end

    // R8: acknowledge left high blocks a new request
    needData = 1'b1;
    waitReq("R8");
    partnerAck = 1'b1;
    repeat (3) step();
    check("R8 request dropped", partnerReq, 0);
    reqEver = 1'b0;
    rc = riseCount;
    for (int n = 0; n < 100 && riseCount < rc + 3; n++) step();
    check("R8 no reissue while ack high", reqEver, 0);
    check("R8 clock runs nominal low", lastLowLen, H);
    check("R8 clock runs nominal high", lastHighLen, H);
    partnerAck = 1'b0;
    waitReq("R8 after ack fell");
    check("R8 reissue on rising edge", highCnt, 1);
    partnerAck = 1'b1;
    needData   = 1'b0;
    repeat (3) step();
    check("R7 final request drop", partnerReq, 0);
    partnerAck = 1'b0;
    repeat (4*H) step();

    // R10 again after exchanges
    reqEver = 1'b0;
    repeat (30) step();
    check("R10 idle no request", reqEver, 0);
    check("R2 idle low length", lastLowLen, H);
    check("R9 idle hold zero", holdCycles, 0);

    finishRun();
  end

endmodule